// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16450/16550-style UART reports and builds the interrupt status byte that software reads. It collects five sources: receive line errors, receive data available, receive FIFO timeout, transmitter holding register empty, and modem line changes. Each is masked by its own enable bit and ranked by a fixed priority. The winner is encoded in the low nibble of the status byte, and the interrupt request line is driven from it.

Sticky sources are held in small set/clear latches. Each one clears under its own register access rule: a line status read, a modem status read, a transmit holding write, or a status read while the transmitter-empty code is the one being returned. The block also owns the receive timeout counter. This counter counts character-time ticks while the receive FIFO holds data and nobody touches it. The FIFO, the shifters and the baud generator sit outside and supply flags and strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: `isr_o[0]` is 0 when at least one enabled source is pending and 1 otherwise. `irq_o` is always the inverse of `isr_o[0]`.
- R2: `isr_o[7:6]` both equal `fifo_en_i`, and `isr_o[5:4]` are always 0.
- R3: Sources are ranked highest to lowest, with `isr_o[3:0]` codes: line status 0110, data available 0100, FIFO timeout 1100, transmitter empty 0010, modem status 0000. When nothing is pending the code is 0001.
- R4: The line status source becomes pending in the cycle after any bit of `lsr_evt_i` is 1 (bit 0 overrun, 1 parity, 2 framing, 3 break). A `lsr_rd_i` pulse with no event in the same cycle clears it.
- R5: The data available source is the level of `rx_ready_i`. This input reports data ready in 16450 mode, or FIFO at or above trigger level in FIFO mode.
- R6: The timeout counter clears on `rbr_rd_i`, on `rx_push_i`, or while `rx_cnt_i` is 0. Otherwise it counts `char_tick_i` pulses up to 4. The timeout source is pending when the count is 4, `rx_cnt_i` is non-zero and `fifo_en_i` is 1. `isr_o[3]` is never 1 when `fifo_en_i` is 0.
- R7: The transmitter empty source becomes pending after a `thr_empty_evt_i` pulse. It clears after a `thr_wr_i` pulse, or after an `isr_rd_i` pulse in a cycle where `isr_o[3:0]` is 0010. A new event in the same cycle wins over a clear.
- R8: The modem source becomes pending after any bit of `msr_chg_i` is 1 (CTS change, DSR change, RI trailing edge, DCD change). A `msr_rd_i` pulse with no change in the same cycle clears it.
- R9: `ien_i` masks sources before ranking: bit 0 data available and timeout, bit 1 transmitter empty, bit 2 line status, bit 3 modem. A masked source keeps its pending state and is reported as soon as its enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO (16550) mode enable |
| ien_i | input | 4 | Per-source interrupt enables |
| lsr_evt_i | input | 4 | Line error events: overrun, parity, framing, break |
| rx_ready_i | input | 1 | Data ready / trigger level reached |
| rx_cnt_i | input | OCC_W | Receive FIFO occupancy |
| rx_push_i | input | 1 | Character written into receive FIFO |
| char_tick_i | input | 1 | One pulse per character time |
| thr_empty_evt_i | input | 1 | Transmit holding register became empty |
| msr_chg_i | input | 4 | Modem change flags: CTS, DSR, RI trailing edge, DCD |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding write strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| isr_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle. These cover the set and clear effect of each sticky latch one cycle later, the timeout dropping after a receive read, the rule that `isr_o[3]` never appears outside FIFO mode, a pending enabled line error always winning the code, and bit 0 agreeing with the masked pending set. Other behaviour only shows up in the bench's scenarios. This includes the full priority order when several sources collide, the transmitter-empty clear that depends on which code a status read returned, the exact tick on which the four-character timeout fires, and masked sources reappearing when their enable is restored.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  // ranking index, 0 = highest
  localparam int unsigned S_LSR = 0;
  localparam int unsigned S_RDA = 1;
  localparam int unsigned S_TO  = 2;
  localparam int unsigned S_THR = 3;
  localparam int unsigned S_MSR = 4;

  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_LSR  = 4'b0110,
    ID_RDA  = 4'b0100,
    ID_TO   = 4'b1100,
    ID_THR  = 4'b0010,
    ID_MSR  = 4'b0000
  } irq_id_e;

  function automatic irq_id_e src_id(int unsigned s);
    case (s)
      S_LSR:   return ID_LSR;
      S_RDA:   return ID_RDA;
      S_TO:    return ID_TO;
      S_THR:   return ID_THR;
      default: return ID_MSR;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_src_latch.sv
module uart_irq_src_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;  // new event wins over clear
    else if (clr_i)  pend_o <= 1'b0;
  end

  a_r4_latch_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  a_r7_latch_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int unsigned OCC_W    = 5,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [OCC_W-1:0] rx_cnt_i,
  input  logic             rx_push_i,
  input  logic             rbr_rd_i,
  input  logic             char_tick_i,
  output logic             to_o
);
  localparam int unsigned CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

  logic [CW-1:0] cnt_q;
  logic          empty, touch;

  assign empty = (rx_cnt_i == '0);
  assign touch = rbr_rd_i | rx_push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (touch || empty)             cnt_q <= '0;
    else if (char_tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign to_o = fifo_en_i && !empty && (cnt_q == LIMIT);

  a_r6_to_cleared_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbr_rd_i |=> !to_o);
  a_r6_to_needs_fifo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_o |-> fifo_en_i);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic [3:0]         id_o
);
  always_comb begin
    id_o = ID_NONE;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (req_i[s]) id_o = src_id(s);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned OCC_W    = 5,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [3:0]       ien_i,
  input  logic [3:0]       lsr_evt_i,
  input  logic             rx_ready_i,
  input  logic [OCC_W-1:0] rx_cnt_i,
  input  logic             rx_push_i,
  input  logic             char_tick_i,
  input  logic             thr_empty_evt_i,
  input  logic [3:0]       msr_chg_i,
  input  logic             rbr_rd_i,
  input  logic             thr_wr_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             isr_rd_i,
  output logic [7:0]       isr_o,
  output logic             irq_o
);
  localparam int unsigned NLATCH = 3;

  logic [NUM_SRC-1:0] pend, req;
  logic [NLATCH-1:0]  l_set, l_clr, l_pend;
  logic [3:0]         id;
  logic               to_pend, thr_shown;

  // sticky sources: 0 line status, 1 tx empty, 2 modem
  assign thr_shown = isr_rd_i && (id == ID_THR);
  assign l_set = {|msr_chg_i, thr_empty_evt_i, |lsr_evt_i};
  assign l_clr = {msr_rd_i, thr_wr_i | thr_shown, lsr_rd_i};

  for (genvar g = 0; g < NLATCH; g++) begin : g_latch
    uart_irq_src_latch u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (l_set[g]),
      .clr_i  (l_clr[g]),
      .pend_o (l_pend[g])
    );
  end

  uart_irq_rx_timeout #(.OCC_W(OCC_W), .TO_CHARS(TO_CHARS)) u_to (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .rx_cnt_i    (rx_cnt_i),
    .rx_push_i   (rx_push_i),
    .rbr_rd_i    (rbr_rd_i),
    .char_tick_i (char_tick_i),
    .to_o        (to_pend)
  );

  always_comb begin
    pend        = '0;
    pend[S_LSR] = l_pend[0];
    pend[S_RDA] = rx_ready_i;
    pend[S_TO]  = to_pend;
    pend[S_THR] = l_pend[1];
    pend[S_MSR] = l_pend[2];
    req         = '0;
    req[S_LSR]  = pend[S_LSR] & ien_i[2];
    req[S_RDA]  = pend[S_RDA] & ien_i[0];
    req[S_TO]   = pend[S_TO]  & ien_i[0];
    req[S_THR]  = pend[S_THR] & ien_i[1];
    req[S_MSR]  = pend[S_MSR] & ien_i[3];
  end

  uart_irq_prio u_prio (
    .req_i (req),
    .id_o  (id)
  );

  assign isr_o = {{2{fifo_en_i}}, 2'b00, id};
  assign irq_o = ~isr_o[0];

  a_r1_bit0_vs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[0] == (req == '0));
  a_r3_lsr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_pend[0] && ien_i[2]) |-> (isr_o[3:0] == 4'b0110));
  a_r6_bit3_fifo_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[3] |-> fifo_en_i);
  a_r8_msr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && msr_chg_i == 4'b0) |=> (l_pend[2] == 1'b0));
  a_r9_mask_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_i[2] && !lsr_rd_i) |=> (l_pend[0] || !$past(l_pend[0])));
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_P = 10;
  localparam int OCC_W = 5;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0;
  logic [3:0] ien = 0, lsr_evt = 0, msr_chg = 0;
  logic rx_ready = 0, rx_push = 0, tick = 0, thr_evt = 0;
  logic [OCC_W-1:0] occ = 0;
  logic rbr_rd = 0, thr_wr = 0, lsr_rd = 0, msr_rd = 0, isr_rd = 0;
  logic [7:0] isr;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic m_lsr = 0, m_thr = 0, m_msr = 0;
  int m_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ident #(.OCC_W(OCC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .ien_i(ien),
    .lsr_evt_i(lsr_evt), .rx_ready_i(rx_ready), .rx_cnt_i(occ),
    .rx_push_i(rx_push), .char_tick_i(tick), .thr_empty_evt_i(thr_evt),
    .msr_chg_i(msr_chg), .rbr_rd_i(rbr_rd), .thr_wr_i(thr_wr),
    .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .isr_rd_i(isr_rd),
    .isr_o(isr), .irq_o(irq)
  );

  function automatic logic [7:0] exp_isr();
    logic to;
    logic [3:0] id;
    to = fifo_en && (occ != 0) && (m_cnt == 4);
    if      (m_lsr && ien[2])             id = 4'b0110;
    else if (rx_ready && ien[0])          id = 4'b0100;
    else if (to && ien[0])                id = 4'b1100;
    else if (m_thr && ien[1])             id = 4'b0010;
    else if (m_msr && ien[3])             id = 4'b0000;
    else                                  id = 4'b0001;
    return {{2{fifo_en}}, 2'b00, id};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs already driven after negedge; check then advance model at posedge
  task automatic step(string req);
    logic [7:0] e;
    #1;
    e = exp_isr();
    check(req, isr, e);
    check("R1 irq", {7'b0, irq}, {7'b0, ~e[0]});
    if (|lsr_evt) m_lsr = 1; else if (lsr_rd) m_lsr = 0;
    if (|msr_chg) m_msr = 1; else if (msr_rd) m_msr = 0;
    if (thr_evt) m_thr = 1;
    else if (thr_wr || (isr_rd && e[3:0] == 4'b0010)) m_thr = 0;
    if (rbr_rd || rx_push || occ == 0) m_cnt = 0;
    else if (tick && m_cnt != 4) m_cnt++;
    @(negedge clk);
    lsr_evt = 0; msr_chg = 0; thr_evt = 0; rx_push = 0; tick = 0;
    rbr_rd = 0; thr_wr = 0; lsr_rd = 0; msr_rd = 0; isr_rd = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    #(CLK_P * 2 + 2);
    // R1 R2 reset state
    check("R1 R2 reset", isr, 8'h01);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R3: all sources pending, peel off by clear rules
    fifo_en = 1; ien = 4'hF;
    lsr_evt = 4'b0100; thr_evt = 1; msr_chg = 4'b0010; step("R4 set");
    rx_ready = 1; step("R3 lsr over rda");
    check("R3 code lsr", isr, 8'hC6);
    lsr_rd = 1; step("R4 lsr read");
    check("R5 rda", isr, 8'hC4);
    rx_ready = 0; step("R3 thr after rda");
    check("R3 thr", isr, 8'hC2);
    // R7: status read while thr shown clears it
    isr_rd = 1; step("R7 isr read");
    check("R7 cleared -> msr", isr, 8'hC0);
    msr_rd = 1; step("R8 msr read");
    check("R8 none", isr, 8'hC1);

    // R7: same-cycle event beats write
    thr_evt = 1; thr_wr = 1; step("R7 set wins");
    check("R7 still set", isr, 8'hC2);
    thr_wr = 1; step("R7 write");
    check("R7 write clears", isr, 8'hC1);

    // R6: timeout after exactly four ticks
    occ = 3; rx_push = 1; step("R6 push");
    for (int i = 0; i < 4; i++) begin
      check("R6 not yet", isr, 8'hC1);
      tick = 1; step("R6 tick");
    end
    check("R6 timeout", isr, 8'hCC);
    fifo_en = 0; #1; check("R6 R2 no bit3 in 16450", isr, 8'h01);
    fifo_en = 1;
    rbr_rd = 1; occ = 2; step("R6 read clears");
    check("R6 cleared", isr, 8'hC1);

    // R9: masked source retained
    ien = 4'b1011; lsr_evt = 4'b0001; step("R9 masked set");
    check("R9 masked", isr, 8'hC1);
    ien = 4'hF; #1; check("R9 unmasked", isr, 8'hC6);
    lsr_rd = 1; step("R9 clear");

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) fifo_en = ~fifo_en;
      if (r[7:4] == 0) ien = 4'($urandom);
      lsr_evt  = (r[10:8] == 0) ? 4'($urandom) : 4'b0;
      msr_chg  = (r[13:11] == 0) ? 4'($urandom) : 4'b0;
      thr_evt  = (r[16:14] == 0);
      thr_wr   = (r[19:17] == 0);
      lsr_rd   = (r[21:20] == 0);
      msr_rd   = (r[23:22] == 0);
      isr_rd   = (r[25:24] == 0);
      tick     = r[26];
      rx_ready = (r[28:27] == 0);
      rx_push  = (r[31:29] == 0);
      rbr_rd   = ($urandom_range(0, 9) == 0);
      if (rx_push && occ != '1) occ++;
      else if (rbr_rd && occ != 0) occ--;
      step("R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule